// File: doc/BRIEF.md
# Interrupt-to-Mailbox Write Bridge

This block converts a set of peripheral interrupt lines into posted memory writes. Each line has its own small register window. The window holds a target mailbox address, an address extension and an enable bit, plus a read-only status word. When an enabled line shows a rising edge, the bridge issues one single-beat write on its master port. The write goes to the programmed address and extension, and its data word is the line's index. A mailbox receiver elsewhere in the chip then turns that write into an interrupt for a chosen core.

An edge is held as a pending flag until the master port accepts its write, so a one-cycle pulse is never lost. A line whose enable bit is clear keeps its flag but issues nothing. Setting the enable bit later sends the held event. When several lines wait at once, the lowest index goes first. Only one write is in flight at a time.

The master port follows valid/ready rules. `wr_valid` rises only when a line is eligible. Once it is high, it and the whole payload stay fixed until the cycle in which `wr_ready` is also high, and that cycle completes the transfer. The receiver may hold `wr_ready` low for any number of cycles. Pending flags keep collecting during that time.

Top module: `irq_mbx_bridge`

## Requirements
- R1: After reset, every enable bit, target address, extension and pending flag is zero, and `wr_valid` is low.
- R2: The register word address is line_index*4 + slot, where slot 0 is the target address, slot 1 the extension (only the low EXT_W bits stored, upper bits read zero), slot 2 the status and slot 3 the enable (bit 0). The status slot is read-only, and writes to it have no effect.
- R3: A rising edge on a line sets its pending flag. A single-cycle pulse is retained. A line held high produces exactly one write. Status bit 0 shows pending, and bit 1 shows the current input level.
- R4: A line whose enable bit is 0 issues no write, and its pending flag is kept.
- R5: Setting the enable bit of a line that is still pending causes its write to be issued.
- R6: Each write carries the line's target address on `wr_addr`, its extension on `wr_ext`, and the line index on `wr_data`.
- R7: When several enabled lines are pending, writes are issued in ascending index order.
- R8: While `wr_valid` is high and `wr_ready` is low, `wr_valid` and the payload stay unchanged, and no other write starts.
- R9: A line's pending flag clears when its write is accepted. A new rising edge in that same cycle keeps the flag set, so a second write follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | N_IRQ | Peripheral interrupt lines |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | $clog2(N_IRQ)+2 | Register word address |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data (combinational from reg_addr) |
| wr_valid | output | 1 | Mailbox write request valid |
| wr_ready | input | 1 | Mailbox write accepted |
| wr_addr | output | ADDR_W | Mailbox target address |
| wr_ext | output | EXT_W | Mailbox address extension |
| wr_data | output | REG_W | Write data: index of the interrupt line |

## Verification
The bench sends a pulse to a disabled line, then checks that nothing is written and that the pending flag survives. A bridge that gated edges with the enable bit would drop the event and never write after the enable is set.

Three lines fire together while the receiver holds back acceptance. A design with a wrong arbiter, or one that changes its payload under back-pressure, shows the wrong index order or a moving `wr_data`.

A line held high must give one write only. Level-triggered logic would flood the port.

A line that re-rises in the exact cycle its write is accepted must give a second write. A design where clearing wins over setting loses that event.

// File: rtl/irq_mbx_pkg.sv
package irq_mbx_pkg;
  // register slot inside each line's four-word window
  typedef enum logic [1:0] {
    SLOT_TARGET = 2'd0,
    SLOT_EXT    = 2'd1,
    SLOT_STATUS = 2'd2,
    SLOT_ENABLE = 2'd3
  } slot_e;

  localparam int unsigned ST_PEND_BIT  = 0;
  localparam int unsigned ST_LEVEL_BIT = 1;
endpackage

// File: rtl/irq_mbx_regs.sv
module irq_mbx_regs
  import irq_mbx_pkg::*;
#(
  parameter int unsigned N_IRQ  = 8,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned EXT_W  = 8,
  parameter int unsigned REG_W  = 32,
  localparam int unsigned IDX_W = $clog2(N_IRQ),
  localparam int unsigned RA_W  = IDX_W + 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reg_we,
  input  logic [RA_W-1:0]               reg_addr,
  input  logic [REG_W-1:0]              reg_wdata,
  output logic [REG_W-1:0]              reg_rdata,
  input  logic [N_IRQ-1:0]              pend,
  input  logic [N_IRQ-1:0]              level,
  output logic [N_IRQ-1:0][ADDR_W-1:0]  tgt_addr,
  output logic [N_IRQ-1:0][EXT_W-1:0]   tgt_ext,
  output logic [N_IRQ-1:0]              enable
);
  logic [IDX_W-1:0] win_idx;
  slot_e            win_slot;

  assign win_idx  = reg_addr[RA_W-1:2];
  assign win_slot = slot_e'(reg_addr[1:0]);

  for (genvar g = 0; g < N_IRQ; g++) begin : g_win
    logic hit;
    assign hit = reg_we && (win_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tgt_addr[g] <= '0;
        tgt_ext[g]  <= '0;
        enable[g]   <= 1'b0;
      end else if (hit) begin
        case (win_slot)
          SLOT_TARGET: tgt_addr[g] <= ADDR_W'(reg_wdata);
          SLOT_EXT:    tgt_ext[g]  <= reg_wdata[EXT_W-1:0];
          SLOT_ENABLE: enable[g]   <= reg_wdata[0];
          default:     ;
        endcase
      end
    end
    // status slot is read-only: a write there leaves the enable unchanged
    AST_STATUS_RO: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && win_slot == SLOT_STATUS) |=> $stable(enable[g])); // R2
  end

  always_comb begin
    reg_rdata = '0;
    if (int'(win_idx) < int'(N_IRQ)) begin
      case (win_slot)
        SLOT_TARGET: reg_rdata = REG_W'(tgt_addr[win_idx]);
        SLOT_EXT:    reg_rdata = REG_W'(tgt_ext[win_idx]);
        SLOT_STATUS: begin
          reg_rdata[ST_PEND_BIT]  = pend[win_idx];
          reg_rdata[ST_LEVEL_BIT] = level[win_idx];
        end
        SLOT_ENABLE: reg_rdata[0] = enable[win_idx];
        default:     reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_mbx_detect.sv
module irq_mbx_detect #(
  parameter int unsigned N_IRQ  = 8,
  localparam int unsigned IDX_W = $clog2(N_IRQ)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq_in,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  output logic [N_IRQ-1:0] pend
);
  logic [N_IRQ-1:0] irq_q;
  logic [N_IRQ-1:0] rise;
  logic [N_IRQ-1:0] clr_vec;

  assign rise    = irq_in & ~irq_q;
  assign clr_vec = clr_en ? (N_IRQ'(1) << clr_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= '0;
      pend  <= '0;
    end else begin
      irq_q <= irq_in;
      // a fresh edge wins over the clear of an accepted write
      pend  <= (pend & ~clr_vec) | rise;
    end
  end

  for (genvar g = 0; g < N_IRQ; g++) begin : g_chk
    AST_EDGE_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_in[g] && !irq_q[g]) |=> pend[g]); // R3
    AST_HELD_WITHOUT_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[g] && !(clr_en && clr_idx == IDX_W'(g))) |=> pend[g]); // R4
  end
endmodule

// File: rtl/irq_mbx_issue.sv
module irq_mbx_issue #(
  parameter int unsigned N_IRQ  = 8,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned EXT_W  = 8,
  parameter int unsigned REG_W  = 32,
  localparam int unsigned IDX_W = $clog2(N_IRQ)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_IRQ-1:0]              pend,
  input  logic [N_IRQ-1:0]              enable,
  input  logic [N_IRQ-1:0][ADDR_W-1:0]  tgt_addr,
  input  logic [N_IRQ-1:0][EXT_W-1:0]   tgt_ext,
  output logic                          wr_valid,
  input  logic                          wr_ready,
  output logic [ADDR_W-1:0]             wr_addr,
  output logic [EXT_W-1:0]              wr_ext,
  output logic [REG_W-1:0]              wr_data,
  output logic                          done,
  output logic [IDX_W-1:0]              done_idx
);
  logic [N_IRQ-1:0] eligible;
  logic [IDX_W-1:0] pick;
  logic             found;
  logic [IDX_W-1:0] sel_q;

  assign eligible = pend & enable;

  // fixed priority: lowest index wins
  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = N_IRQ - 1; i >= 0; i--) begin
      if (eligible[i]) begin
        pick  = IDX_W'(i);
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_ext   <= '0;
      wr_data  <= '0;
      sel_q    <= '0;
    end else if (wr_valid) begin
      if (wr_ready) wr_valid <= 1'b0;
    end else if (found) begin
      wr_valid <= 1'b1;
      wr_addr  <= tgt_addr[pick];
      wr_ext   <= tgt_ext[pick];
      wr_data  <= REG_W'(pick);
      sel_q    <= pick;
    end
  end

  assign done     = wr_valid && wr_ready;
  assign done_idx = sel_q;

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_ext)
                                 && $stable(wr_data))); // R8
endmodule

// File: rtl/irq_mbx_bridge.sv
module irq_mbx_bridge #(
  parameter int unsigned N_IRQ  = 8,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned EXT_W  = 8,
  parameter int unsigned REG_W  = 32,
  localparam int unsigned IDX_W = $clog2(N_IRQ),
  localparam int unsigned RA_W  = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IRQ-1:0]  irq_in,
  input  logic              reg_we,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [EXT_W-1:0]  wr_ext,
  output logic [REG_W-1:0]  wr_data
);
  logic [N_IRQ-1:0]             pend;
  logic [N_IRQ-1:0]             enable;
  logic [N_IRQ-1:0][ADDR_W-1:0] tgt_addr;
  logic [N_IRQ-1:0][EXT_W-1:0]  tgt_ext;
  logic                         done;
  logic [IDX_W-1:0]             done_idx;

  irq_mbx_regs #(.N_IRQ(N_IRQ), .ADDR_W(ADDR_W), .EXT_W(EXT_W), .REG_W(REG_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pend(pend), .level(irq_in),
    .tgt_addr(tgt_addr), .tgt_ext(tgt_ext), .enable(enable)
  );

  irq_mbx_detect #(.N_IRQ(N_IRQ)) u_detect (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .clr_en(done), .clr_idx(done_idx), .pend(pend)
  );

  irq_mbx_issue #(.N_IRQ(N_IRQ), .ADDR_W(ADDR_W), .EXT_W(EXT_W), .REG_W(REG_W)) u_issue (
    .clk(clk), .rst_n(rst_n), .pend(pend), .enable(enable),
    .tgt_addr(tgt_addr), .tgt_ext(tgt_ext), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_ext(wr_ext), .wr_data(wr_data),
    .done(done), .done_idx(done_idx)
  );

  // checker-side copy of the eligible set one cycle back
  logic [N_IRQ-1:0] elig_d;
  logic [IDX_W-1:0] wr_idx;
  logic [N_IRQ-1:0] below_idx;
  always_ff @(posedge clk) begin
    if (!rst_n) elig_d <= '0;
    else        elig_d <= pend & enable;
  end
  assign wr_idx    = wr_data[IDX_W-1:0];
  assign below_idx = (N_IRQ'(1) << wr_idx) - N_IRQ'(1);

  AST_ISSUE_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> elig_d[wr_idx]); // R4
  AST_ISSUE_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> ((elig_d & below_idx) == '0)); // R7
  AST_DATA_IS_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_data < REG_W'(N_IRQ))); // R6
  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(!rst_n) |-> !wr_valid); // R1
endmodule

// File: tb/tb_irq_mbx_bridge.sv
module tb_irq_mbx_bridge;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] irq_in = '0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        wr_valid;
  logic        wr_ready = 1'b0;
  logic [31:0] wr_addr;
  logic [7:0]  wr_ext;
  logic [31:0] wr_data;

  always #5 clk = ~clk;

  irq_mbx_bridge dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_ext(wr_ext), .wr_data(wr_data)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // transfer log: inputs change on negedges only, so posedge values are settled
  int          log_n = 0;
  logic [31:0] log_d [0:63];
  logic [31:0] log_a [0:63];
  logic [7:0]  log_e [0:63];
  always @(posedge clk) begin
    if (rst_n && wr_valid && wr_ready && log_n < 64) begin
      log_d[log_n] <= wr_data;
      log_a[log_n] <= wr_addr;
      log_e[log_n] <= wr_ext;
      log_n <= log_n + 1;
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(int idx, int slot, logic [31:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 5'(idx * 4 + slot); reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rreg(int idx, int slot, output logic [31:0] v);
    @(negedge clk);
    reg_addr = 5'(idx * 4 + slot);
    #1 v = reg_rdata;
  endtask

  task automatic setup_line(int idx, logic [31:0] a, logic [7:0] e, bit en);
    wreg(idx, 0, a);
    wreg(idx, 1, {24'h0, e});
    wreg(idx, 3, {31'h0, en});
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1", "wr_valid after reset", {31'h0, wr_valid}, 0);
    rreg(0, 0, v); chk("R1", "target 0", v, 0);
    rreg(4, 1, v); chk("R1", "ext 4", v, 0);
    rreg(7, 3, v); chk("R1", "enable 7", v, 0);
    rreg(2, 2, v); chk("R1", "status 2", v, 0);
  endtask

  task automatic t_regmap;
    logic [31:0] v;
    wreg(2, 0, 32'hA000_1000);
    wreg(2, 1, 32'hFFFF_FF5A);
    rreg(2, 0, v); chk("R2", "target readback", v, 32'hA000_1000);
    rreg(2, 1, v); chk("R2", "ext truncated", v, 32'h0000_005A);
    rreg(3, 0, v); chk("R2", "neighbour window untouched", v, 0);
    wreg(5, 3, 32'hFFFF_FFFF);
    rreg(5, 3, v); chk("R2", "enable bit", v, 1);
    wreg(5, 2, 32'h3);
    rreg(5, 2, v); chk("R2", "status ignores write", v, 0);
    rreg(5, 3, v); chk("R2", "status write leaves enable", v, 1);
    wreg(5, 3, 0);
  endtask

  task automatic t_masked;
    logic [31:0] v;
    int base;
    setup_line(3, 32'h3000_0040, 8'h13, 1'b0);
    wr_ready = 1'b1;
    base = log_n;
    @(negedge clk) irq_in[3] = 1'b1;
    @(negedge clk) irq_in[3] = 1'b0;
    cyc(8);
    chk("R4", "no write while disabled", log_n - base, 0);
    chk("R4", "wr_valid low while disabled", {31'h0, wr_valid}, 0);
    rreg(3, 2, v); chk("R3", "pulse kept pending", v, 1);
    wreg(3, 3, 1);
    cyc(6);
    chk("R5", "write after enable", log_n - base, 1);
    chk("R6", "data is index", log_d[base], 3);
    chk("R6", "address", log_a[base], 32'h3000_0040);
    chk("R6", "extension", {24'h0, log_e[base]}, 32'h13);
    rreg(3, 2, v); chk("R9", "pending cleared on accept", v, 0);
  endtask

  task automatic t_level;
    logic [31:0] v;
    int base;
    setup_line(1, 32'h1111_0000, 8'h01, 1'b1);
    base = log_n;
    @(negedge clk) irq_in[1] = 1'b1;
    cyc(12);
    chk("R3", "held level gives one write", log_n - base, 1);
    rreg(1, 2, v); chk("R3", "status shows level only", v, 2);
    @(negedge clk) irq_in[1] = 1'b0;
    cyc(2);
  endtask

  task automatic t_prio;
    int base;
    logic [31:0] a0;
    setup_line(6, 32'h6000_0006, 8'h66, 1'b1);
    setup_line(2, 32'h2000_0002, 8'h22, 1'b1);
    setup_line(4, 32'h4000_0004, 8'h44, 1'b1);
    wr_ready = 1'b0;
    base = log_n;
    @(negedge clk) begin irq_in[6] = 1'b1; irq_in[2] = 1'b1; irq_in[4] = 1'b1; end
    @(negedge clk) irq_in = '0;
    cyc(2);
    chk("R7", "first offered is lowest", wr_data, 2);
    chk("R8", "valid raised", {31'h0, wr_valid}, 1);
    a0 = wr_addr;
    cyc(5);
    chk("R8", "valid held under stall", {31'h0, wr_valid}, 1);
    chk("R8", "data held under stall", wr_data, 2);
    chk("R8", "address held under stall", wr_addr, a0);
    chk("R8", "nothing accepted while stalled", log_n - base, 0);
    wr_ready = 1'b1;
    cyc(10);
    chk("R7", "three writes", log_n - base, 3);
    chk("R7", "order first", log_d[base], 2);
    chk("R7", "order second", log_d[base + 1], 4);
    chk("R7", "order third", log_d[base + 2], 6);
    chk("R6", "third address", log_a[base + 2], 32'h6000_0006);
  endtask

  task automatic t_reassert;
    int base;
    setup_line(0, 32'h0000_0F00, 8'h0F, 1'b1);
    wr_ready = 1'b1;
    base = log_n;
    // 1,0,1: second edge lands on the acceptance cycle of the first write
    @(negedge clk) irq_in[0] = 1'b1;
    @(negedge clk) irq_in[0] = 1'b0;
    @(negedge clk) irq_in[0] = 1'b1;
    @(negedge clk) irq_in[0] = 1'b0;
    cyc(8);
    chk("R9", "edge at accept gives second write", log_n - base, 2);
    chk("R9", "second write index", log_d[base + 1], 0);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_regmap;
    t_masked;
    t_level;
    t_prio;
    t_reassert;
    summary;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary;
  end
endmodule